// File: doc/BRIEF.md
# SMBus Transaction Sequencer

This block is the control state machine that carries one SMBus command-protocol transaction to completion. It drives a byte-level I2C master engine, and the engine does the SCL/SDA bit timing. The sequencer never touches the wires. It asks the engine for start and stop conditions, writes or reads the engine's data register, and keeps an ACK-control level that tells the engine whether to acknowledge the byte now being received. The engine reports three events: SDA-ready, bus error and NACK. It also shows whether it currently owns the bus as master.

A request carries a 7-bit target address, a read flag, a command byte and a transfer kind: quick, send/receive byte, byte data, word data or block data. Payload bytes pass through a simple buffer port. The sequencer presents an index and reads the byte back in the same cycle, or it writes a received byte at that index. When the transaction ends, the sequencer gives a one-cycle `done` pulse with a 2-bit result code. It also gives a needs-reset flag that tells the owner the engine must be reinitialised.

The states are IDLE, ADDRESS, COMMAND, RSTART, QUICK, READ and WRITE. The transitions are:
- IDLE→QUICK for quick and byte kinds.
- IDLE→ADDRESS for the data kinds.
- ADDRESS→COMMAND.
- COMMAND→RSTART on a read.
- COMMAND→WRITE on a write.
- RSTART/QUICK→READ or →WRITE, chosen by the read flag.
- READ→READ until the count is used up, then READ→IDLE.
- WRITE→WRITE until the count is used up, then WRITE→IDLE.
- Any busy state→IDLE on a bus error, loss of mastership, NACK or timeout.

Top module: `smbus_seq`

## Requirements
- R1: The address byte is `{req_addr, req_read}`, with bit 0 = 1 meaning read. Kind codes: 0 quick, 1 byte, 2 byte data, 3 word data, 4 block data. Codes 5 to 7 are unknown. Kinds 0 and 1 enter QUICK and kinds 2 to 4 enter ADDRESS, each with one start issued on acceptance.
- R2: Data kinds (2 to 4) first write the address byte with bit 0 forced to 0, then the command byte. A write continues in WRITE. A read issues a start together with the address byte carrying bit 0 = 1, then continues in READ.
- R3: Kinds 0 and 1 skip the command phase. On the first SDA-ready event they write the address byte with the real read flag.
- R4: Each SDA-ready event in WRITE writes the next payload byte. After the last byte, the next event issues a stop and ends with result 0 (OK). A byte-kind write sends the command byte as its single payload byte.
- R5: Each READ event reads the data register and stores it at consecutive buffer indices. On the final byte the same event issues a stop and ends with OK. `eng_ack_ctl` becomes 1 after the action that is taken with exactly one byte remaining, and 0 after earlier actions.
- R6: Word data moves two bytes, first byte at index 0. Block data takes its count from buffer index 0 and moves its payload at indices 1 and up.
- R7: A bus-error event, or any event while `st_master` is 0, ends the transaction with result 2 (I/O error) and `needs_reset` = 1, with no stop. This check takes priority over NACK.
- R8: A NACK event in any busy state issues a stop and a flag clear in the same cycle. It ends with result 1 (no device) and `needs_reset` = 0.
- R9: If no event arrives within `cfg_timeout` cycles after entry or after the last event, the transaction ends with result 2 and `needs_reset` = 1.
- R10: An unknown kind, or a read whose length is 0, ends at once with result 3 (invalid) and no engine operation.
- R11: `req_ready` is high only when idle and not pulsing `done`. `done` lasts one cycle. Engine events while idle cause no operation and no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_timeout | input | TMO_W | Event timeout in cycles |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_addr | input | 7 | Target address |
| req_read | input | 1 | 1 = read transfer |
| req_cmd | input | 8 | Command byte |
| req_kind | input | 3 | Transfer kind code |
| buf_idx | output | LEN_W+1 | Buffer index (0 when idle) |
| buf_rdata | input | 8 | Buffer byte at `buf_idx` |
| buf_we | output | 1 | Store `buf_wdata` at `buf_idx` |
| buf_wdata | output | 8 | Received byte |
| eng_start | output | 1 | Request a (repeated) start |
| eng_stop | output | 1 | Request a stop |
| eng_wr | output | 1 | Write `eng_wdata` to the engine data register |
| eng_wdata | output | 8 | Byte to send |
| eng_rd | output | 1 | Take the received byte from the engine |
| eng_rdata | input | 8 | Engine data register |
| eng_ack_ctl | output | 1 | 1 = do not acknowledge the byte being received |
| eng_clr_flags | output | 1 | Clear the NACK and stall flags |
| st_sda_ready | input | 1 | Engine ready for the next byte operation |
| st_bus_err | input | 1 | Bus error seen |
| st_nack | input | 1 | Target did not acknowledge |
| st_master | input | 1 | Engine owns the bus |
| done | output | 1 | One-cycle end-of-transaction pulse |
| result | output | 2 | 0 OK, 1 no device, 2 I/O error, 3 invalid |
| needs_reset | output | 1 | Engine must be reinitialised |

## Verification
The bench sweeps every kind code in both directions over several addresses and block counts. It injects a NACK, a bus error, a loss of mastership, a combined error-plus-NACK and a silent engine after each engine operation in turn. A sequencer that skipped the command-first write would show a read address where a write address belongs. One that set ACK control one byte early would leave the receiver short of data. One that let a NACK outrank a bus error would issue a stop and report no device instead of asking for a reset. The bench also covers zero-length reads, unknown kinds and events while idle: a design that started the bus on an invalid request, or acted on a stray event, leaves operations in the engine log that should be empty.

// File: rtl/smbus_seq_pkg.sv
package smbus_seq_pkg;

    localparam logic [2:0] KIND_QUICK     = 3'd0;
    localparam logic [2:0] KIND_BYTE      = 3'd1;
    localparam logic [2:0] KIND_BYTE_DATA = 3'd2;
    localparam logic [2:0] KIND_WORD      = 3'd3;
    localparam logic [2:0] KIND_BLOCK     = 3'd4;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_NODEV   = 2'd1,
        RES_IOERR   = 2'd2,
        RES_INVALID = 2'd3
    } res_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDRESS,
        S_COMMAND,
        S_RSTART,
        S_QUICK,
        S_READ,
        S_WRITE
    } state_e;

endpackage

// File: rtl/smbus_seq_decode.sv
module smbus_seq_decode
    import smbus_seq_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic [2:0]       kind,
    input  logic             rd,
    input  logic [7:0]       first_byte,
    output logic [LEN_W-1:0] len,
    output logic             base_one,
    output logic             use_cmd,
    output logic             quick_entry,
    output logic             invalid
);

    always_comb begin
        len         = '0;
        base_one    = 1'b0;
        use_cmd     = 1'b0;
        quick_entry = 1'b0;
        invalid     = 1'b0;
        case (kind)
            KIND_QUICK: quick_entry = 1'b1;
            KIND_BYTE: begin
                quick_entry = 1'b1;
                len         = LEN_W'(1);
                use_cmd     = !rd;
            end
            KIND_BYTE_DATA: len = LEN_W'(1);
            KIND_WORD:      len = LEN_W'(2);
            KIND_BLOCK: begin
                len      = LEN_W'(first_byte);
                base_one = 1'b1;
            end
            default: invalid = 1'b1;
        endcase
        if (rd && len == '0)
            invalid = 1'b1;
    end

endmodule

// File: rtl/smbus_seq_watch.sv
module smbus_seq_watch #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             kick,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);

    logic [TMO_W-1:0] cnt_q;

    assign expired = active && (cnt_q >= limit);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!active || kick)
            cnt_q <= '0;
        else if (!expired)
            cnt_q <= cnt_q + 1'b1;
    end

    // R9: the wait counter never runs past the programmed limit
    p_tmo_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> cnt_q <= limit);

endmodule

// File: rtl/smbus_seq.sv
module smbus_seq
    import smbus_seq_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int TMO_W = 16,
    localparam int IDX_W = LEN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMO_W-1:0] cfg_timeout,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [6:0]       req_addr,
    input  logic             req_read,
    input  logic [7:0]       req_cmd,
    input  logic [2:0]       req_kind,
    output logic [IDX_W-1:0] buf_idx,
    input  logic [7:0]       buf_rdata,
    output logic             buf_we,
    output logic [7:0]       buf_wdata,
    output logic             eng_start,
    output logic             eng_stop,
    output logic             eng_wr,
    output logic [7:0]       eng_wdata,
    output logic             eng_rd,
    input  logic [7:0]       eng_rdata,
    output logic             eng_ack_ctl,
    output logic             eng_clr_flags,
    input  logic             st_sda_ready,
    input  logic             st_bus_err,
    input  logic             st_nack,
    input  logic             st_master,
    output logic             done,
    output logic [1:0]       result,
    output logic             needs_reset
);

    state_e           state_q, state_d;
    logic [7:0]       addr_q, cmd_q;
    logic [LEN_W-1:0] len_q, len_d;
    logic [IDX_W-1:0] ptr_q, ptr_d;
    logic             usecmd_q, ack_q, ack_d;
    logic             done_q, nrst_q;
    res_e             res_q;
    logic             fin, fin_nrst, latch;
    res_e             fin_res;

    logic [LEN_W-1:0] dec_len;
    logic             dec_base, dec_usecmd, dec_quick, dec_invalid;
    logic             busy, ev, fault, nacked, step, tmo_expired, accept;

    assign busy   = (state_q != S_IDLE);
    assign ev     = st_sda_ready || st_bus_err || st_nack;
    assign fault  = ev && (st_bus_err || !st_master);
    assign nacked = ev && !fault && st_nack;
    assign step   = ev && !fault && !st_nack;

    assign req_ready   = !busy && !done_q;
    assign accept      = req_valid && req_ready;
    assign done        = done_q;
    assign result      = res_q;
    assign needs_reset = nrst_q;
    assign eng_ack_ctl = ack_q;

    smbus_seq_decode #(.LEN_W(LEN_W)) u_decode (
        .kind        (req_kind),
        .rd          (req_read),
        .first_byte  (buf_rdata),
        .len         (dec_len),
        .base_one    (dec_base),
        .use_cmd     (dec_usecmd),
        .quick_entry (dec_quick),
        .invalid     (dec_invalid)
    );

    smbus_seq_watch #(.TMO_W(TMO_W)) u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (busy),
        .kick    (ev),
        .limit   (cfg_timeout),
        .expired (tmo_expired)
    );

    // Output and next-state process
    always_comb begin
        eng_start     = 1'b0;
        eng_stop      = 1'b0;
        eng_wr        = 1'b0;
        eng_rd        = 1'b0;
        eng_clr_flags = 1'b0;
        eng_wdata     = '0;
        buf_we        = 1'b0;
        buf_idx       = busy ? ptr_q : '0;
        buf_wdata     = eng_rdata;
        state_d       = state_q;
        len_d         = len_q;
        ptr_d         = ptr_q;
        ack_d         = ack_q;
        fin           = 1'b0;
        fin_res       = RES_OK;
        fin_nrst      = 1'b0;
        latch         = 1'b0;
        if (!busy) begin
            if (accept) begin
                latch = 1'b1;
                if (dec_invalid) begin
                    fin     = 1'b1;
                    fin_res = RES_INVALID;
                end else begin
                    eng_start = 1'b1;
                    state_d   = dec_quick ? S_QUICK : S_ADDRESS;
                end
            end
        end else if (fault) begin
            fin      = 1'b1;
            fin_res  = RES_IOERR;
            fin_nrst = 1'b1;
            state_d  = S_IDLE;
        end else if (nacked) begin
            eng_stop      = 1'b1;
            eng_clr_flags = 1'b1;
            fin           = 1'b1;
            fin_res       = RES_NODEV;
            state_d       = S_IDLE;
        end else if (step) begin
            unique case (state_q)
                S_ADDRESS: begin
                    eng_wr    = 1'b1;
                    eng_wdata = {addr_q[7:1], 1'b0};
                    state_d   = S_COMMAND;
                end
                S_COMMAND: begin
                    eng_wr    = 1'b1;
                    eng_wdata = cmd_q;
                    state_d   = addr_q[0] ? S_RSTART : S_WRITE;
                end
                S_RSTART, S_QUICK: begin
                    eng_start = (state_q == S_RSTART);
                    eng_wr    = 1'b1;
                    eng_wdata = addr_q;
                    if (addr_q[0]) begin
                        ack_d   = (len_q == LEN_W'(1));
                        state_d = S_READ;
                    end else begin
                        state_d = S_WRITE;
                    end
                end
                S_READ: begin
                    ack_d  = (len_q == LEN_W'(1));
                    eng_rd = 1'b1;
                    buf_we = 1'b1;
                    len_d  = len_q - LEN_W'(1);
                    ptr_d  = ptr_q + IDX_W'(1);
                    if (len_q == LEN_W'(1)) begin
                        eng_stop = 1'b1;
                        fin      = 1'b1;
                        state_d  = S_IDLE;
                    end
                end
                S_WRITE: begin
                    if (len_q == '0) begin
                        eng_stop = 1'b1;
                        fin      = 1'b1;
                        state_d  = S_IDLE;
                    end else begin
                        eng_wr    = 1'b1;
                        eng_wdata = usecmd_q ? cmd_q : buf_rdata;
                        len_d     = len_q - LEN_W'(1);
                        ptr_d     = ptr_q + IDX_W'(1);
                    end
                end
                default: ;
            endcase
        end else if (tmo_expired) begin
            fin      = 1'b1;
            fin_res  = RES_IOERR;
            fin_nrst = 1'b1;
            state_d  = S_IDLE;
        end
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            addr_q   <= '0;
            cmd_q    <= '0;
            len_q    <= '0;
            ptr_q    <= '0;
            usecmd_q <= 1'b0;
            ack_q    <= 1'b0;
            done_q   <= 1'b0;
            res_q    <= RES_OK;
            nrst_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            len_q   <= len_d;
            ptr_q   <= ptr_d;
            ack_q   <= ack_d;
            done_q  <= fin;
            if (fin) begin
                res_q  <= fin_res;
                nrst_q <= fin_nrst;
            end
            if (latch) begin
                addr_q   <= {req_addr, req_read};
                cmd_q    <= req_cmd;
                usecmd_q <= dec_usecmd;
                len_q    <= dec_len;
                ptr_q    <= IDX_W'(dec_base);
            end
        end
    end

    // R11: completion is a single-cycle pulse
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: bus error while busy ends with I/O error and a reset request
    p_buserr_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_bus_err) |=> (done && result == RES_IOERR && needs_reset));

    // R8: a NACK alone ends with the no-device code and no reset request
    p_nack_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_nack && st_master && !st_bus_err)
            |=> (done && result == RES_NODEV && !needs_reset));

    // R9: an expired wait with no event ends as an I/O error
    p_timeout_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_expired && !ev) |=> (done && result == RES_IOERR && needs_reset));

    // R5: reading with one byte left leaves ACK control set
    p_ack_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rd && len_q == LEN_W'(1)) |=> eng_ack_ctl);

    // R10: an invalid request never produced a start
    p_invalid_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_INVALID) |-> !$past(eng_start));

endmodule

// File: tb/tb_smbus_seq.sv
module tb_smbus_seq;

    localparam int LEN_W = 8;
    localparam int TMO_W = 16;
    localparam int IDX_W = LEN_W + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [TMO_W-1:0] cfg_timeout = 16'd12;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [6:0]       req_addr = '0;
    logic             req_read = 1'b0;
    logic [7:0]       req_cmd = '0;
    logic [2:0]       req_kind = '0;
    logic [IDX_W-1:0] buf_idx;
    logic [7:0]       buf_rdata;
    logic             buf_we;
    logic [7:0]       buf_wdata;
    logic             eng_start, eng_stop, eng_wr, eng_rd, eng_ack_ctl, eng_clr_flags;
    logic [7:0]       eng_wdata, eng_rdata;
    logic             st_sda_ready, st_bus_err, st_nack, st_master;
    logic             done;
    logic [1:0]       result;
    logic             needs_reset;

    always #4 clk = ~clk;

    smbus_seq #(.LEN_W(LEN_W), .TMO_W(TMO_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_timeout(cfg_timeout),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_read(req_read), .req_cmd(req_cmd), .req_kind(req_kind),
        .buf_idx(buf_idx), .buf_rdata(buf_rdata), .buf_we(buf_we), .buf_wdata(buf_wdata),
        .eng_start(eng_start), .eng_stop(eng_stop), .eng_wr(eng_wr), .eng_wdata(eng_wdata),
        .eng_rd(eng_rd), .eng_rdata(eng_rdata), .eng_ack_ctl(eng_ack_ctl),
        .eng_clr_flags(eng_clr_flags), .st_sda_ready(st_sda_ready), .st_bus_err(st_bus_err),
        .st_nack(st_nack), .st_master(st_master), .done(done), .result(result),
        .needs_reset(needs_reset)
    );

    // ---------------- engine and buffer model ----------------
    logic [7:0]  wbuf [0:15];
    logic [7:0]  rbuf [0:15];
    logic [12:0] oplog [0:31];
    logic        acklog [0:15];
    int          lc, ridx;
    logic [7:0]  rcnt;
    int          acnt, cur;
    logic        sda, nk, be, mst, pend, rd_d, poke;
    logic [1:0]  dly;
    logic        clr_log = 1'b0;
    int          fault_kind = 0;
    int          fault_at = 255;

    assign buf_rdata    = wbuf[buf_idx[3:0]];
    assign eng_rdata    = 8'h3C + rcnt * 8'd17;
    assign st_sda_ready = sda | poke;
    assign st_bus_err   = be;
    assign st_nack      = nk;
    assign st_master    = mst;

    always @(posedge clk) begin
        if (clr_log) begin
            lc <= 0; ridx <= 0; rcnt <= '0; acnt <= 0; cur <= 0;
            sda <= 1'b0; nk <= 1'b0; be <= 1'b0; mst <= 1'b0; pend <= 1'b0;
            rd_d <= 1'b0; dly <= '0;
            for (int i = 0; i < 16; i++) begin
                rbuf[i]   <= 8'h00;
                acklog[i] <= 1'b0;
            end
        end else begin
            rd_d <= eng_rd;
            if (rd_d && ridx > 0)
                acklog[ridx-1] <= eng_ack_ctl;
            if ((eng_start | eng_stop | eng_wr | eng_rd | eng_clr_flags) && lc < 32) begin
                oplog[lc] <= {eng_start, eng_stop, eng_wr, eng_rd, eng_clr_flags,
                              eng_wr ? eng_wdata : 8'h00};
                lc <= lc + 1;
            end
            if (buf_we)
                rbuf[buf_idx[3:0]] <= buf_wdata;
            if (eng_rd) begin
                rcnt <= rcnt + 8'd1;
                ridx <= ridx + 1;
            end
            if (eng_clr_flags)
                nk <= 1'b0;
            if (eng_start | eng_wr | eng_rd) begin
                sda  <= 1'b0;
                pend <= 1'b1;
                dly  <= 2'd2;
                cur  <= acnt;
                acnt <= acnt + 1;
                if (eng_start)
                    mst <= 1'b1;
            end else if (pend) begin
                if (dly != 0) begin
                    dly <= dly - 2'd1;
                end else begin
                    pend <= 1'b0;
                    if (cur == fault_at) begin
                        case (fault_kind)
                            1: nk <= 1'b1;
                            2: be <= 1'b1;
                            3: begin mst <= 1'b0; sda <= 1'b1; end
                            4: ;
                            5: begin be <= 1'b1; nk <= 1'b1; end
                            default: sda <= 1'b1;
                        endcase
                    end else begin
                        sda <= 1'b1;
                    end
                end
            end
            if (eng_stop) begin
                pend <= 1'b0;
                sda  <= 1'b0;
                mst  <= 1'b0;
            end
        end
    end

    // ---------------- checking ----------------
    int nchk = 0;
    int nfail = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    logic [12:0] exp_ops [0:31];
    int ne, nact;

    function automatic logic [12:0] opc(input bit s, input bit p, input bit w,
                                        input bit r, input bit c, input logic [7:0] d);
        return {s, p, w, r, c, d};
    endfunction

    task automatic push(input logic [12:0] v);
        exp_ops[ne] = v;
        ne++;
    endtask

    task automatic build_exp(input int kind, input bit rd, input logic [6:0] addr,
                             input logic [7:0] cmd, output int n, output int base,
                             output bit invalid);
        ne = 0; nact = 0; base = 0; invalid = 0;
        case (kind)
            0: n = 0;
            1: n = 1;
            2: n = 1;
            3: n = 2;
            4: begin n = int'(wbuf[0]); base = 1; end
            default: begin n = 0; invalid = 1; end
        endcase
        if (rd && n == 0) invalid = 1;
        if (invalid) return;
        push(opc(1, 0, 0, 0, 0, 8'h00));
        if (kind <= 1) begin
            if (rd) begin
                push(opc(0, 0, 1, 0, 0, {addr, 1'b1}));
                for (int i = 0; i < n; i++) push(opc(0, i == n-1, 0, 1, 0, 8'h00));
            end else begin
                push(opc(0, 0, 1, 0, 0, {addr, 1'b0}));
                if (n == 1) push(opc(0, 0, 1, 0, 0, cmd));
                push(opc(0, 1, 0, 0, 0, 8'h00));
            end
        end else begin
            push(opc(0, 0, 1, 0, 0, {addr, 1'b0}));
            push(opc(0, 0, 1, 0, 0, cmd));
            if (rd) begin
                push(opc(1, 0, 1, 0, 0, {addr, 1'b1}));
                for (int i = 0; i < n; i++) push(opc(0, i == n-1, 0, 1, 0, 8'h00));
            end else begin
                for (int i = 0; i < n; i++) push(opc(0, 0, 1, 0, 0, wbuf[base+i]));
                push(opc(0, 1, 0, 0, 0, 8'h00));
            end
        end
        for (int i = 0; i < ne; i++)
            if (!exp_ops[i][11]) nact++;
    endtask

    task automatic run(input int kind, input bit rd, input logic [6:0] addr,
                       input logic [7:0] cmd, input int fk, input int fa);
        int n, base, exp_res, got_res, wait_cnt, k;
        bit invalid, exp_nrst, got_nrst, seen, ok;
        string tag;
        build_exp(kind, rd, addr, cmd, n, base, invalid);
        if (fk != 0 && (invalid || fa >= nact)) return;
        exp_res = 0; exp_nrst = 0;
        if (invalid) begin
            exp_res = 3; ne = 0; tag = "R10";
        end else if (fk != 0) begin
            ne = fa + 1;
            case (fk)
                1: begin exp_res = 1; push(opc(0, 1, 0, 0, 1, 8'h00)); tag = "R8"; end
                4: begin exp_res = 2; exp_nrst = 1; tag = "R9"; end
                default: begin exp_res = 2; exp_nrst = 1; tag = "R7"; end
            endcase
        end else begin
            tag = (kind <= 1) ? "R3" : "R2";
        end
        @(negedge clk);
        clr_log = 1'b1; fault_kind = fk; fault_at = (fk != 0) ? fa : 255;
        @(negedge clk);
        clr_log = 1'b0;
        check(req_ready == 1'b1, "R11", "ready before request", req_ready, 1);
        req_kind = 3'(kind); req_read = rd; req_addr = addr; req_cmd = cmd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        seen = 0; got_res = 0; got_nrst = 0;
        for (wait_cnt = 0; wait_cnt < 400; wait_cnt++) begin
            if (done) begin
                seen = 1; got_res = int'(result); got_nrst = needs_reset;
                break;
            end
            @(negedge clk);
        end
        check(seen, tag, "done pulse", seen, 1);
        @(negedge clk);
        check(!done, "R11", "done single cycle", done, 0);
        repeat (4) @(negedge clk);
        check(got_res == exp_res, tag, "result", got_res, exp_res);
        check(got_nrst == exp_nrst, tag, "needs_reset", got_nrst, exp_nrst);
        ok = (lc == ne); k = 0;
        if (ok)
            for (int i = 0; i < ne; i++)
                if (oplog[i] != exp_ops[i]) begin ok = 0; k = i; break; end
        if (lc != ne)
            check(0, tag, "R1 engine op count", lc, ne);
        else
            check(ok, tag, "R1 engine op sequence", oplog[k], exp_ops[k]);
        if (!invalid && fk == 0 && rd) begin
            for (int i = 0; i < n; i++) begin
                check(rbuf[base+i] == 8'(8'h3C + i*17), (kind >= 3) ? "R6" : "R5",
                      "stored byte", rbuf[base+i], 8'(8'h3C + i*17));
                check(acklog[i] == (i == n-1), "R5", "ACK control after read",
                      acklog[i], (i == n-1));
            end
        end
        if (!invalid && fk == 0 && !rd)
            check(ok, (kind >= 3) ? "R6" : "R4", "payload written", lc, ne);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        poke = 1'b0;
        for (int i = 0; i < 16; i++) wbuf[i] = 8'(i*37 + 5);
        clr_log = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        clr_log = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R11", "reset ready", req_ready, 1);
        check(done == 1'b0, "R11", "reset done", done, 0);
        check(needs_reset == 1'b0, "R11", "reset needs_reset", needs_reset, 0);
        check({eng_start, eng_stop, eng_wr, eng_rd} == 4'b0, "R11", "reset engine ops",
              {eng_start, eng_stop, eng_wr, eng_rd}, 0);

        // R11: stray events while idle
        @(negedge clk); clr_log = 1'b1;
        @(negedge clk); clr_log = 1'b0; poke = 1'b1;
        begin
            bit saw = 0;
            repeat (6) begin
                @(negedge clk);
                if (done) saw = 1;
            end
            poke = 1'b0;
            check(!saw, "R11", "done on idle event", saw, 0);
            check(lc == 0, "R11", "ops on idle event", lc, 0);
        end

        // normal sweep over kinds, directions, addresses and block counts
        for (int kind = 0; kind < 8; kind++)
            for (int rd = 0; rd < 2; rd++)
                for (int a = 0; a < 3; a++)
                    for (int bl = 0; bl < 3; bl++) begin
                        logic [6:0] addr;
                        addr = (a == 0) ? 7'h00 : (a == 1) ? 7'h55 : 7'h7F;
                        for (int i = 0; i < 16; i++) wbuf[i] = 8'(i*37 + int'(addr) + 5);
                        wbuf[0] = (bl == 0) ? 8'd0 : (bl == 1) ? 8'd1 : 8'd3;
                        if (kind == 4 || bl == 0)
                            run(kind, rd[0], addr, 8'(8'hA5 ^ (kind*16 + a)), 0, 0);
                    end

        // fault sweep: each fault after each engine operation
        for (int kind = 0; kind < 5; kind++)
            for (int rd = 0; rd < 2; rd++)
                for (int fk = 1; fk < 6; fk++)
                    for (int fa = 0; fa < 8; fa++) begin
                        for (int i = 0; i < 16; i++) wbuf[i] = 8'(i*11 + 3);
                        wbuf[0] = 8'd2;
                        run(kind, rd[0], 7'h2B, 8'h9C, fk, fa);
                    end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule